// File: doc/BRIEF.md
# Flash Prefetch Speculation Buffer

This block sits between a set of bus masters and a wide flash read port. It keeps two one-line stores. The recent-line buffer holds the line that was fetched or used most recently. The speculation buffer holds the line that follows the most recent demand miss.

A read request names a byte address, an access type (instruction or data) and the requesting master. If the line is in either store, the block answers from that store. Otherwise it reads the line from flash and returns it. After that demand read completes, the block may read the next sequential line into the speculation buffer. The flash side uses a req/ack handshake. The flash array answers after a fixed number of wait states.

Speculation depends on three settings: a disable bit for each master, an enable for instruction accesses and a separate enable for data accesses. An invalidate strobe that carries a 1 empties both stores at once. The line size can be 32 or 64 bits, and it sets how a byte address maps to a line number.

Controller states:
- `ST_IDLE` accepts requests.
- `ST_DEMAND` waits for the flash ack of a missed line.
- `ST_SPEC` waits for the speculative next-line read.

Transitions:
- `ST_IDLE` goes to `ST_DEMAND` on a miss.
- `ST_DEMAND` goes to `ST_SPEC` on an ack when speculation is allowed.
- `ST_DEMAND` goes to `ST_IDLE` on an ack when speculation is not allowed.
- `ST_SPEC` goes to `ST_IDLE` on an ack.

A hit leaves the controller in `ST_IDLE`.

Top module: `fspec_top`

## Requirements
- R1: Out of reset, `m_ready` is 1, `r_valid` is 0 and `f_req` is 0, and both stores are empty, so the first read misses.
- R2: A demand miss raises `f_req` with `f_addr` set to the line number of the request. The response carries the flash data of that line and appears the cycle after `f_ack`.
- R3: `cfg_width` 2'b00 selects 32-bit lines (line = address >> 2). The encodings 2'b01, 2'b10 and 2'b11 all select 64-bit lines (line = address >> 3).
- R4: With `cfg_seb_en`=1, a read of the line held in the recent-line buffer responds on the cycle after acceptance, and no flash read takes place.
- R5: With `cfg_seb_en`=0, every demand read goes to flash, even when either store holds the line.
- R6: When a miss is allowed to speculate, the next cycle after the demand ack issues a flash read of line+1, and the result fills the speculation buffer. A later read of that line responds in one cycle with no flash read, and that line becomes the recent line.
- R7: Speculation is suppressed when the disable bit of the requesting master is set (bit index = `m_mid`). It is also suppressed for instruction accesses (`m_is_data`=0) when `cfg_ipf_en`=0, and for data accesses (`m_is_data`=1) when `cfg_dpf_en`=0.
- R8: An `inv_wr` strobe with `inv_data`=1 empties both stores in the next cycle. A strobe with `inv_data`=0 has no effect.
- R9: When an invalidate arrives while a speculative read is outstanding, the returning data is discarded and the speculation buffer stays empty.
- R10: While a flash read is outstanding, `m_ready` is 0, and `f_addr` stays stable until `f_ack`.
- R11: Each accepted request produces exactly one single-cycle `r_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pf_dis | input | NUM_M | Per-master speculation disable |
| cfg_ipf_en | input | 1 | Allow speculation on instruction accesses |
| cfg_dpf_en | input | 1 | Allow speculation on data accesses |
| cfg_seb_en | input | 1 | Recent-line buffer enable (also gates hits) |
| cfg_width | input | 2 | Line size select, 00 = 32 bit, others = 64 bit |
| inv_wr | input | 1 | Invalidate strobe |
| inv_data | input | 1 | Invalidate value, only 1 acts |
| m_valid | input | 1 | Read request valid |
| m_ready | output | 1 | Request accepted when high with m_valid |
| m_addr | input | ADDR_W | Byte address |
| m_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| m_mid | input | MID_W | Requesting master |
| r_valid | output | 1 | Response valid pulse |
| r_data | output | DATA_W | Response line data |
| f_req | output | 1 | Flash read request |
| f_addr | output | LINE_W | Flash line number |
| f_ack | input | 1 | Flash data valid pulse |
| f_data | input | DATA_W | Flash line data |

## Verification
Directed sequences exercise each source a response can come from: a cold miss, a repeat of the same line, a read of the speculated next line, and a second read after that line has moved to the recent-line buffer. These cases separate the hit paths by latency and by the count of flash reads. The gating cases change one of master disable, instruction enable or data enable at a time, and the following-line read then shows whether a speculative fetch took place. Invalidates with value 0 and 1 are tried. One invalidate is placed inside an outstanding speculative read. Random traffic over a small pool of lines, with random masters, access types, settings, line sizes and invalidates, mixes all of these against a reference model of the two stores.

// File: rtl/fspec_pkg.sv
package fspec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DEMAND = 2'd1,
        ST_SPEC   = 2'd2
    } fspec_state_e;

    localparam logic [1:0] WIDTH_32 = 2'b00;

    // byte-to-line shift: 32-bit lines shift by 2, every other code by 3
    function automatic logic [1:0] line_shift(input logic [1:0] width_sel);
        return (width_sel == WIDTH_32) ? 2'd2 : 2'd3;
    endfunction

endpackage

// File: rtl/fspec_line.sv
module fspec_line
    import fspec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LINE_W = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        width_sel,
    output logic [LINE_W-1:0] line,
    output logic [LINE_W-1:0] line_next
);

    logic [ADDR_W-1:0] shifted;

    always_comb begin
        shifted   = addr >> line_shift(width_sel);
        line      = shifted[LINE_W-1:0];
        line_next = line + LINE_W'(1);
    end

endmodule

// File: rtl/fspec_gate.sv
module fspec_gate #(
    parameter int NUM_M = 8,
    parameter int MID_W = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
    input  logic [NUM_M-1:0] pf_dis,
    input  logic [MID_W-1:0] mid,
    input  logic             is_data,
    input  logic             ipf_en,
    input  logic             dpf_en,
    output logic             allow
);

    logic [NUM_M-1:0] master_ok;

    generate
        for (genvar g = 0; g < NUM_M; g++) begin : g_master
            assign master_ok[g] = (mid == MID_W'(g)) && !pf_dis[g];
        end
    endgenerate

    logic type_ok;
    assign type_ok = is_data ? dpf_en : ipf_en;
    assign allow   = (|master_ok) && type_ok;

endmodule

// File: rtl/fspec_entry.sv
module fspec_entry #(
    parameter int LINE_W = 14,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [LINE_W-1:0] ld_line,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [LINE_W-1:0] probe,
    output logic              vld,
    output logic [DATA_W-1:0] data,
    output logic              hit
);

    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld    <= 1'b0;
            line_q <= '0;
            data   <= '0;
        end else if (clr) begin
            vld <= 1'b0;
        end else if (load) begin
            vld    <= 1'b1;
            line_q <= ld_line;
            data   <= ld_data;
        end
    end

    assign hit = vld && (line_q == probe);

endmodule

// File: rtl/fspec_ctrl.sv
module fspec_ctrl
    import fspec_pkg::*;
#(
    parameter int LINE_W = 14,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_valid,
    output logic              m_ready,
    input  logic [LINE_W-1:0] req_line,
    input  logic [LINE_W-1:0] req_next,
    input  logic              allow_in,
    input  logic              seb_en,
    input  logic              seb_hit,
    input  logic              spec_hit,
    input  logic [DATA_W-1:0] seb_data,
    input  logic [DATA_W-1:0] spec_data,
    input  logic              inv_now,
    input  logic              f_ack,
    input  logic [DATA_W-1:0] f_data,
    output logic              f_req,
    output logic [LINE_W-1:0] f_addr,
    output logic              r_valid,
    output logic [DATA_W-1:0] r_data,
    output logic              seb_load,
    output logic [LINE_W-1:0] seb_ld_line,
    output logic [DATA_W-1:0] seb_ld_data,
    output logic              spec_load,
    output logic              spec_take,
    output logic [LINE_W-1:0] spec_ld_line
);

    fspec_state_e state, state_nx;

    logic [LINE_W-1:0] line_q, next_q;
    logic              allow_q, kill_q;
    logic              accept, use_seb, use_spec, any_hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs and next state
    always_comb begin
        state_nx    = state;
        m_ready     = 1'b0;
        f_req       = 1'b0;
        f_addr      = line_q;
        accept      = 1'b0;
        use_seb     = 1'b0;
        use_spec    = 1'b0;
        any_hit     = 1'b0;
        seb_load    = 1'b0;
        seb_ld_line = line_q;
        seb_ld_data = f_data;
        spec_load   = 1'b0;
        spec_take   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                m_ready  = 1'b1;
                accept   = m_valid;
                use_seb  = seb_en && seb_hit;
                use_spec = seb_en && spec_hit && !use_seb;
                any_hit  = use_seb || use_spec;
                if (accept && use_spec) begin
                    seb_load    = 1'b1;
                    seb_ld_line = req_line;
                    seb_ld_data = spec_data;
                    spec_take   = 1'b1;
                end
                if (accept && !any_hit) state_nx = ST_DEMAND;
            end
            ST_DEMAND: begin
                f_req = 1'b1;
                if (f_ack) begin
                    seb_load = seb_en;
                    state_nx = allow_q ? ST_SPEC : ST_IDLE;
                end
            end
            ST_SPEC: begin
                f_req  = 1'b1;
                f_addr = next_q;
                if (f_ack) begin
                    spec_load = !kill_q && !inv_now;
                    state_nx  = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign spec_ld_line = next_q;

    // request context, kill flag and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= '0;
            next_q  <= '0;
            allow_q <= 1'b0;
            kill_q  <= 1'b0;
            r_valid <= 1'b0;
            r_data  <= '0;
        end else begin
            if (accept) begin
                line_q  <= req_line;
                next_q  <= req_next;
                allow_q <= allow_in;
            end
            kill_q  <= (state == ST_SPEC && !f_ack) ? (kill_q || inv_now) : 1'b0;
            r_valid <= (accept && any_hit) || (state == ST_DEMAND && f_ack);
            if (accept && any_hit) r_data <= use_seb ? seb_data : spec_data;
            else if (state == ST_DEMAND && f_ack) r_data <= f_data;
        end
    end

    a_r4_hit_no_flash: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && m_valid && seb_en && seb_hit) |=> (state == ST_IDLE && r_valid));

    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && m_valid && !seb_en) |=> (state == ST_DEMAND));

    a_r6_spec_next: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEMAND && f_ack && allow_q) |=>
            (state == ST_SPEC && f_req && f_addr == $past(line_q + LINE_W'(1))));

    a_r7_no_spec: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEMAND && f_ack && !allow_q) |=> (state == ST_IDLE && !f_req));

    a_r11_resp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        r_valid |-> $past((state == ST_IDLE && m_valid) || (state == ST_DEMAND && f_ack)));

endmodule

// File: rtl/fspec_top.sv
module fspec_top
    import fspec_pkg::*;
#(
    parameter int NUM_M  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 64,
    localparam int MID_W  = (NUM_M > 1) ? $clog2(NUM_M) : 1,
    localparam int LINE_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_M-1:0]  cfg_pf_dis,
    input  logic              cfg_ipf_en,
    input  logic              cfg_dpf_en,
    input  logic              cfg_seb_en,
    input  logic [1:0]        cfg_width,
    input  logic              inv_wr,
    input  logic              inv_data,
    input  logic              m_valid,
    output logic              m_ready,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_is_data,
    input  logic [MID_W-1:0]  m_mid,
    output logic              r_valid,
    output logic [DATA_W-1:0] r_data,
    output logic              f_req,
    output logic [LINE_W-1:0] f_addr,
    input  logic              f_ack,
    input  logic [DATA_W-1:0] f_data
);

    logic [LINE_W-1:0] req_line, req_next;
    logic              allow, inv_now;
    logic              seb_vld, seb_hit, spec_vld, spec_hit;
    logic [DATA_W-1:0] seb_data, spec_data;
    logic              seb_load, spec_load, spec_take;
    logic [LINE_W-1:0] seb_ld_line, spec_ld_line;
    logic [DATA_W-1:0] seb_ld_data;

    assign inv_now = inv_wr && inv_data;

    fspec_line #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_line (
        .addr(m_addr), .width_sel(cfg_width), .line(req_line), .line_next(req_next)
    );

    fspec_gate #(.NUM_M(NUM_M), .MID_W(MID_W)) u_gate (
        .pf_dis(cfg_pf_dis), .mid(m_mid), .is_data(m_is_data),
        .ipf_en(cfg_ipf_en), .dpf_en(cfg_dpf_en), .allow(allow)
    );

    fspec_entry #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_seb (
        .clk(clk), .rst_n(rst_n), .clr(inv_now), .load(seb_load),
        .ld_line(seb_ld_line), .ld_data(seb_ld_data), .probe(req_line),
        .vld(seb_vld), .data(seb_data), .hit(seb_hit)
    );

    fspec_entry #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_spec (
        .clk(clk), .rst_n(rst_n), .clr(inv_now || spec_take), .load(spec_load),
        .ld_line(spec_ld_line), .ld_data(f_data), .probe(req_line),
        .vld(spec_vld), .data(spec_data), .hit(spec_hit)
    );

    fspec_ctrl #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .m_valid(m_valid), .m_ready(m_ready),
        .req_line(req_line), .req_next(req_next), .allow_in(allow),
        .seb_en(cfg_seb_en), .seb_hit(seb_hit), .spec_hit(spec_hit),
        .seb_data(seb_data), .spec_data(spec_data), .inv_now(inv_now),
        .f_ack(f_ack), .f_data(f_data), .f_req(f_req), .f_addr(f_addr),
        .r_valid(r_valid), .r_data(r_data), .seb_load(seb_load),
        .seb_ld_line(seb_ld_line), .seb_ld_data(seb_ld_data),
        .spec_load(spec_load), .spec_take(spec_take), .spec_ld_line(spec_ld_line)
    );

    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        inv_now |=> (!seb_vld && !spec_vld));

    a_r9_fill_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spec_vld) |-> $past(f_ack && !inv_now));

    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        f_req |-> !m_ready);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (f_req && !f_ack) |=> (f_req && $stable(f_addr)));

endmodule

// File: tb/fspec_top_bench.sv
module fspec_top_bench;
    localparam int NM = 8, AW = 16, DW = 64, MW = 3, LW = 14, WAIT = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic [NM-1:0] cfg_pf_dis;
    logic          cfg_ipf_en, cfg_dpf_en, cfg_seb_en;
    logic [1:0]    cfg_width;
    logic          inv_wr, inv_data;
    logic          m_valid, m_ready, m_is_data;
    logic [AW-1:0] m_addr;
    logic [MW-1:0] m_mid;
    logic          r_valid, f_req;
    logic [DW-1:0] r_data, f_data;
    logic [LW-1:0] f_addr;
    logic          f_ack;

    fspec_top #(.NUM_M(NM), .ADDR_W(AW), .DATA_W(DW)) u_fspec_top (
        .clk(clk), .rst_n(rst_n), .cfg_pf_dis(cfg_pf_dis), .cfg_ipf_en(cfg_ipf_en),
        .cfg_dpf_en(cfg_dpf_en), .cfg_seb_en(cfg_seb_en), .cfg_width(cfg_width),
        .inv_wr(inv_wr), .inv_data(inv_data), .m_valid(m_valid), .m_ready(m_ready),
        .m_addr(m_addr), .m_is_data(m_is_data), .m_mid(m_mid), .r_valid(r_valid),
        .r_data(r_data), .f_req(f_req), .f_addr(f_addr), .f_ack(f_ack), .f_data(f_data)
    );

    int total = 0, bad = 0;
    logic [LW-1:0] flog [256];
    int fcnt = 0, wcnt = 0;

    logic          m_seb_v, m_sp_v;
    logic [LW-1:0] m_seb, m_sp;

    function automatic logic [DW-1:0] fdata(input logic [LW-1:0] ln);
        logic [31:0] x;
        x = {18'h0, ln};
        return {~x ^ 32'h0F0F_3C3C, x * 32'h0000_9E37 + 32'h1234_5678};
    endfunction

    function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a, input logic [1:0] w);
        logic [AW-1:0] s;
        s = (w == 2'b00) ? (a >> 2) : (a >> 3);
        return s[LW-1:0];
    endfunction

    // flash array: fixed wait states, one-cycle ack with data
    always @(posedge clk) begin
        if (!rst_n) begin
            f_ack <= 1'b0;
            f_data <= '0;
            wcnt <= 0;
        end else if (f_ack) begin
            f_ack <= 1'b0;
        end else if (f_req) begin
            if (wcnt == WAIT - 1) begin
                f_ack <= 1'b1;
                f_data <= fdata(f_addr);
                flog[fcnt[7:0]] <= f_addr;
                fcnt <= fcnt + 1;
                wcnt <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_inv(input bit v);
        @(negedge clk);
        inv_wr = 1'b1;
        inv_data = v;
        @(negedge clk);
        inv_wr = 1'b0;
        inv_data = 1'b0;
        if (v) begin
            m_seb_v = 1'b0;
            m_sp_v = 1'b0;
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit isd, input logic [MW-1:0] mid,
                           input bit inv_spec, input string tag);
        logic [LW-1:0] ln;
        bit hit_seb, hit_sp, hit, spec;
        int c0, n, exp_cnt;
        ln = line_of(a, cfg_width);
        hit_seb = cfg_seb_en && m_seb_v && (m_seb == ln);
        hit_sp = cfg_seb_en && !hit_seb && m_sp_v && (m_sp == ln);
        hit = hit_seb || hit_sp;
        spec = !hit && !cfg_pf_dis[mid] && (isd ? cfg_dpf_en : cfg_ipf_en);
        n = 0;
        while (!m_ready && n < 200) begin @(negedge clk); n++; end
        c0 = fcnt;
        m_valid = 1'b1; m_addr = a; m_is_data = isd; m_mid = mid;
        @(negedge clk);
        m_valid = 1'b0;
        if (hit) begin
            chk(r_valid === 1'b1, {tag, hit_seb ? " R4 recent-line hit in one cycle" : " R6 spec hit in one cycle"},
                64'(r_valid), 64'd1);
        end else begin
            chk(!m_ready, {tag, " R10 not ready while flash busy"}, 64'(m_ready), 64'd0);
            chk(f_req && f_addr == ln, {tag, " R2 R3 demand line address"}, 64'(f_addr), 64'(ln));
            n = 0;
            while (!r_valid && n < 100) begin @(negedge clk); n++; end
        end
        chk(r_valid && r_data == fdata(ln), {tag, " R2 response data"}, r_data, fdata(ln));
        @(negedge clk);
        chk(!r_valid, {tag, " R11 single response pulse"}, 64'(r_valid), 64'd0);
        if (spec && inv_spec) begin
            inv_wr = 1'b1; inv_data = 1'b1;
            @(negedge clk);
            inv_wr = 1'b0; inv_data = 1'b0;
        end
        n = 0;
        while (!m_ready && n < 200) begin @(negedge clk); n++; end
        exp_cnt = hit ? 0 : (spec ? 2 : 1);
        chk(fcnt - c0 == exp_cnt,
            {tag, hit ? " R4 R6 no flash read on hit" : (spec ? " R6 speculative read issued" : " R7 R5 no speculation")},
            64'(fcnt - c0), 64'(exp_cnt));
        if (spec) begin
            chk(flog[8'(c0 + 1)] == ln + LW'(1), {tag, " R6 speculative line is next"},
                64'(flog[8'(c0 + 1)]), 64'(ln + LW'(1)));
        end
        if (hit_sp) begin
            m_seb = ln; m_seb_v = 1'b1; m_sp_v = 1'b0;
        end
        if (!hit) begin
            if (cfg_seb_en) begin m_seb = ln; m_seb_v = 1'b1; end
            if (spec) begin
                if (inv_spec) begin m_seb_v = 1'b0; m_sp_v = 1'b0; end
                else begin m_sp = ln + LW'(1); m_sp_v = 1'b1; end
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_pf_dis = '0; cfg_ipf_en = 1'b1; cfg_dpf_en = 1'b1; cfg_seb_en = 1'b1;
        cfg_width = 2'b00; inv_wr = 1'b0; inv_data = 1'b0;
        m_valid = 1'b0; m_addr = '0; m_is_data = 1'b0; m_mid = '0;
        m_seb_v = 1'b0; m_sp_v = 1'b0; m_seb = '0; m_sp = '0;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(m_ready === 1'b1, "R1 ready after reset", 64'(m_ready), 64'd1);
        chk(r_valid === 1'b0, "R1 no response after reset", 64'(r_valid), 64'd0);
        chk(f_req === 1'b0, "R1 no flash request after reset", 64'(f_req), 64'd0);

        do_read(16'h0040, 1'b0, 3'd0, 1'b0, "R1 cold miss");
        do_read(16'h0042, 1'b0, 3'd0, 1'b0, "R4 same line");
        do_read(16'h0044, 1'b0, 3'd0, 1'b0, "R6 next line");
        do_read(16'h0044, 1'b1, 3'd0, 1'b0, "R6 moved to recent");
        do_inv(1'b0);
        do_read(16'h0044, 1'b0, 3'd0, 1'b0, "R8 zero write kept");
        do_inv(1'b1);
        do_read(16'h0044, 1'b0, 3'd0, 1'b0, "R8 cleared");

        cfg_pf_dis = 8'h08;
        do_read(16'h0100, 1'b1, 3'd3, 1'b0, "R7 master disabled");
        do_read(16'h0104, 1'b1, 3'd3, 1'b0, "R7 master disabled follow");
        do_read(16'h0180, 1'b1, 3'd2, 1'b0, "R7 other master");
        cfg_pf_dis = '0;
        cfg_ipf_en = 1'b0;
        do_read(16'h0200, 1'b0, 3'd1, 1'b0, "R7 instr off");
        do_read(16'h0300, 1'b1, 3'd1, 1'b0, "R7 data on");
        cfg_ipf_en = 1'b1; cfg_dpf_en = 1'b0;
        do_read(16'h0400, 1'b1, 3'd2, 1'b0, "R7 data off");
        do_read(16'h0480, 1'b0, 3'd2, 1'b0, "R7 instr on");
        cfg_dpf_en = 1'b1;

        do_read(16'h0500, 1'b0, 3'd0, 1'b1, "R9 kill");
        do_read(16'h0504, 1'b0, 3'd0, 1'b0, "R9 discarded line");

        cfg_seb_en = 1'b0;
        do_read(16'h0600, 1'b0, 3'd0, 1'b0, "R5 off first");
        do_read(16'h0600, 1'b0, 3'd0, 1'b0, "R5 off repeat");
        do_read(16'h0604, 1'b0, 3'd0, 1'b0, "R5 off spec line");
        cfg_seb_en = 1'b1;

        for (int w = 0; w < 4; w++) begin
            do_inv(1'b1);
            cfg_width = 2'(w);
            do_read(16'h0738, 1'b1, 3'd4, 1'b0, "R3 width code");
        end

        for (int i = 0; i < 300; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) do_inv(1'($urandom));
            if (r == 1) cfg_pf_dis = 8'($urandom);
            if (r == 2) begin cfg_ipf_en = 1'($urandom); cfg_dpf_en = 1'($urandom); end
            if (r == 3) cfg_seb_en = ($urandom % 4) != 0;
            if (r == 4) cfg_width = 2'($urandom);
            do_read(AW'($urandom % 128), 1'($urandom), 3'($urandom), ($urandom % 8) == 0, "R6 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule